// File: doc/BRIEF.md
# TDM Frame-Master Serial Transmitter

This block sits at the transmit end of a time-division multiplexed serial highway and owns the frame timing. It watches a serial bit clock, counts bit periods into frames of a fixed length, and drives a frame-sync pulse that marks the first bit of every frame. Alongside it shifts out bytes taken from a one-byte holding register, most significant bit first.

All timing choices are made at run time through static control inputs. These are the output level of the sync pulse, the bit-clock edge that launches data, the bit-clock edge that launches sync, and whether the bit clock runs at one or two times the bit rate. The controls are expected to change only while the transmitter is disabled. The serial clock is sampled by the system clock through a short synchronizer, so every output moves a fixed number of system cycles after the chosen bit-clock edge.

While the enable is low the line idles at one and no sync pulse is produced. Raising it starts a new frame at bit 0 on the next launch edge. When the holding register is empty at a byte boundary, the transmitter sends an all-ones byte and raises an underrun flag for that byte.

Top module: `tdm_fs_tx`

## Requirements
- R1: After reset `sdata` is 1, `fsync` is 0, `underrun` is 0 and `hold_take` is 0.
- R2: While `tx_en` is 0, `sdata` is 1, `fsync` sits at its inactive level (equal to `fs_pol`), `underrun` is 0 and no byte is taken. This takes effect one system cycle after `tx_en` falls.
- R3: Each data bit is launched on the bit-clock edge chosen by `data_edge` (0 = falling, 1 = rising). Bytes leave most significant bit first.
- R4: With `dbl_rate` = 0 each bit lasts one bit-clock period. With `dbl_rate` = 1 it lasts two, starting on the first launch edge after enable.
- R5: The sync pulse covers frame bit 0 and recurs every `FRAME_BITS` bits. Its active level is high when `fs_pol` = 0 and low when `fs_pol` = 1.
- R6: The sync output changes only on the bit-clock edge chosen by `fs_edge` (0 = falling, 1 = rising). At that edge it takes the value for the bit then on the line.
- R7: At every byte boundary (frame bit index a multiple of 8) the holding byte is loaded and `hold_take` pulses for one system cycle if `hold_valid` is 1. Otherwise 8 one-bits are sent and `underrun` is 1 for that byte.
- R8: The first bit after `tx_en` rises is frame bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk | input | 1 | Serial bit clock, slower than `clk` |
| tx_en | input | 1 | Transmit enable |
| fs_pol | input | 1 | Sync level: 0 active high, 1 active low |
| data_edge | input | 1 | Data launch edge: 0 falling, 1 rising |
| fs_edge | input | 1 | Sync launch edge: 0 falling, 1 rising |
| dbl_rate | input | 1 | 1 = bit clock at twice the bit rate |
| hold_data | input | 8 | Holding-register byte |
| hold_valid | input | 1 | Holding register has a byte |
| hold_take | output | 1 | One-cycle pulse when the byte is consumed |
| sdata | output | 1 | Serial data out |
| fsync | output | 1 | Frame sync out |
| underrun | output | 1 | Current byte is idle fill |

## Verification
A bit counter that drifts shows up as a sync pulse on the wrong bit, or on a wrong frame length. That is visible on `fsync` within one frame, and on `hold_take` at the next byte boundary. A wrong half-rate phase shows as a data bit cut to one bit-clock period within the first two bits. A stale sync register shows as a pulse on the wrong edge within half a bit-clock period of frame start. A bad shift register corrupts `sdata` on the very next launch edge.

// File: rtl/tdm_tx_pkg.sv
package tdm_tx_pkg;
  // Next frame bit index, wrapping at the frame length.
  function automatic int unsigned idx_advance(int unsigned idx, int unsigned len);
    return (idx + 1 >= len) ? 0 : idx + 1;
  endfunction

  // True when a bit index opens a new byte.
  function automatic logic at_byte_start(int unsigned idx, int unsigned bw);
    return (idx % bw) == 0;
  endfunction
endpackage

// File: rtl/sclk_edges.sv
module sclk_edges #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sclk,
  input  logic data_edge,
  input  logic fs_edge,
  output logic data_ev,
  output logic fs_ev
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic prev_q, rise, fall;

  for (genvar g = 0; g < SYNC_STAGES; g++) begin : g_sync
    if (g == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) sync_q[g] <= 1'b0;
        else        sync_q[g] <= sclk;
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) sync_q[g] <= 1'b0;
        else        sync_q[g] <= sync_q[g-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= sync_q[SYNC_STAGES-1];

  assign rise    = sync_q[SYNC_STAGES-1] & ~prev_q;
  assign fall    = ~sync_q[SYNC_STAGES-1] & prev_q;
  assign data_ev = data_edge ? rise : fall;
  assign fs_ev   = fs_edge ? rise : fall;
endmodule

// File: rtl/bit_timer.sv
module bit_timer (
  input  logic clk,
  input  logic rst_n,
  input  logic tx_en,
  input  logic dbl,
  input  logic data_ev,
  output logic bit_ev
);
  logic phase_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)               phase_q <= 1'b0;
    else if (!tx_en)          phase_q <= 1'b0;
    else if (data_ev && dbl)  phase_q <= ~phase_q;

  assign bit_ev = data_ev & (~dbl | ~phase_q);

  // R4: a bit started in 2x mode leaves the second half pending
  p_half_pending_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_en && $past(tx_en && dbl && bit_ev)) |-> phase_q);
endmodule

// File: rtl/tx_shifter.sv
module tx_shifter #(
  parameter int FRAME_BITS = 256,
  parameter int BYTE_W     = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tx_en,
  input  logic              bit_ev,
  input  logic [BYTE_W-1:0] hold_data,
  input  logic              hold_valid,
  output logic              hold_take,
  output logic              sdata,
  output logic              underrun,
  output logic              line_first,
  output logic              first_after
);
  import tdm_tx_pkg::*;
  localparam int IDXW = (FRAME_BITS > 1) ? $clog2(FRAME_BITS) : 1;

  logic              running_q, udr_q;
  logic [IDXW-1:0]   idx_q, nxt_idx;
  logic [BYTE_W-1:0] shreg_q;
  logic              load;

  assign nxt_idx     = running_q ? IDXW'(idx_advance(32'(idx_q), FRAME_BITS)) : '0;
  assign load        = !running_q || at_byte_start(32'(nxt_idx), BYTE_W);
  assign first_after = (nxt_idx == '0);
  assign line_first  = running_q && (idx_q == '0);
  assign hold_take   = tx_en && bit_ev && load && hold_valid;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      running_q <= 1'b0;
      idx_q     <= '0;
      udr_q     <= 1'b0;
      shreg_q   <= '1;
    end else if (!tx_en) begin
      running_q <= 1'b0;
      idx_q     <= '0;
      udr_q     <= 1'b0;
      shreg_q   <= '1;
    end else if (bit_ev) begin
      running_q <= 1'b1;
      idx_q     <= nxt_idx;
      if (load) begin
        shreg_q <= hold_valid ? hold_data : '1;
        udr_q   <= !hold_valid;
      end else begin
        shreg_q <= {shreg_q[BYTE_W-2:0], 1'b1};
      end
    end

  assign sdata    = (tx_en && running_q) ? shreg_q[BYTE_W-1] : 1'b1;
  assign underrun = tx_en && running_q && udr_q;

  // R2: disabling stops the frame
  p_off_stops_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_en |=> !running_q);
  // R3: the line only moves after a launch event
  p_sdata_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_en && $past(tx_en) && !$past(bit_ev)) |-> $stable(sdata));
endmodule

// File: rtl/fs_gen.sv
module fs_gen (
  input  logic clk,
  input  logic rst_n,
  input  logic tx_en,
  input  logic fs_ev,
  input  logic bit_ev,
  input  logic line_first,
  input  logic first_after,
  input  logic fs_pol,
  output logic fsync
);
  logic fs_on_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)      fs_on_q <= 1'b0;
    else if (!tx_en) fs_on_q <= 1'b0;
    else if (fs_ev)  fs_on_q <= bit_ev ? first_after : line_first;

  assign fsync = (fs_on_q & tx_en) ^ fs_pol;

  // R5: sync only starts while frame bit 0 is on the line
  p_fs_first_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fs_on_q) |-> line_first);
  // R6: sync state moves only after a sync launch edge
  p_fs_edge_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_en && $past(tx_en) && !$past(fs_ev)) |-> $stable(fs_on_q));
endmodule

// File: rtl/tdm_fs_tx.sv
module tdm_fs_tx #(
  parameter int FRAME_BITS  = 256,
  parameter int BYTE_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sclk,
  input  logic              tx_en,
  input  logic              fs_pol,
  input  logic              data_edge,
  input  logic              fs_edge,
  input  logic              dbl_rate,
  input  logic [BYTE_W-1:0] hold_data,
  input  logic              hold_valid,
  output logic              hold_take,
  output logic              sdata,
  output logic              fsync,
  output logic              underrun
);
  logic data_ev, fs_ev, bit_ev, line_first, first_after;

  sclk_edges #(.SYNC_STAGES(SYNC_STAGES)) i_edges (
    .clk(clk), .rst_n(rst_n), .sclk(sclk), .data_edge(data_edge),
    .fs_edge(fs_edge), .data_ev(data_ev), .fs_ev(fs_ev));

  bit_timer i_timer (
    .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .dbl(dbl_rate),
    .data_ev(data_ev), .bit_ev(bit_ev));

  tx_shifter #(.FRAME_BITS(FRAME_BITS), .BYTE_W(BYTE_W)) i_shift (
    .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .bit_ev(bit_ev),
    .hold_data(hold_data), .hold_valid(hold_valid), .hold_take(hold_take),
    .sdata(sdata), .underrun(underrun), .line_first(line_first),
    .first_after(first_after));

  fs_gen i_fs (
    .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .fs_ev(fs_ev), .bit_ev(bit_ev),
    .line_first(line_first), .first_after(first_after), .fs_pol(fs_pol),
    .fsync(fsync));

  // R7: idle fill is all ones
  p_underrun_ones_r7: assert property (@(posedge clk) disable iff (!rst_n)
    underrun |-> sdata);
endmodule

// File: tb/test_tdm_fs_tx.sv
module test_tdm_fs_tx;
  localparam int CLK_PERIOD = 10;
  localparam int FB         = 16;
  localparam int SYNC       = 2;
  localparam int LIMIT      = 150000;

  logic clk = 1'b0, rst_n = 1'b0, sclk = 1'b0, tx_en = 1'b0;
  logic fs_pol = 1'b0, data_edge = 1'b0, fs_edge = 1'b0, dbl_rate = 1'b0;
  logic [7:0] hold_data = 8'h00;
  logic hold_valid = 1'b0;
  logic hold_take, sdata, fsync, underrun;
  int n_chk = 0, n_bad = 0, takes = 0;

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) if (hold_take) takes++;

  tdm_fs_tx #(.FRAME_BITS(FB), .BYTE_W(8), .SYNC_STAGES(SYNC)) i_tdm_fs_tx (
    .clk(clk), .rst_n(rst_n), .sclk(sclk), .tx_en(tx_en), .fs_pol(fs_pol),
    .data_edge(data_edge), .fs_edge(fs_edge), .dbl_rate(dbl_rate),
    .hold_data(hold_data), .hold_valid(hold_valid), .hold_take(hold_take),
    .sdata(sdata), .fsync(fsync), .underrun(underrun));

  // {pol, data_edge, fs_edge, dbl, valid, byte}
  localparam logic [12:0] VECS [6] = '{
    {1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 8'hA5},
    {1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 8'h3C},
    {1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 8'h96},
    {1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 8'hC3},
    {1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 8'h81},
    {1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 8'h00}};

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic step(input logic lvl);
    @(negedge clk) sclk = lvl;
    repeat (SYNC + 2) @(negedge clk);
  endtask

  task automatic run_vec(input logic [12:0] v, input int nbits);
    logic pol, de, fe, dbl, val;
    logic [7:0] dat;
    int bit_no, periods;
    logic ph, fsx, ed, eu;
    {pol, de, fe, dbl, val, dat} = v;
    @(negedge clk) tx_en = 1'b0;
    fs_pol = pol; data_edge = de; fs_edge = fe; dbl_rate = dbl;
    hold_valid = val; hold_data = dat; sclk = de;
    repeat (SYNC + 3) @(negedge clk);
    takes = 0;
    tx_en = 1'b1;
    bit_no = -1; ph = 1'b0; fsx = 1'b0;
    periods = nbits * (dbl ? 2 : 1);
    for (int p = 0; p < periods; p++) begin
      for (int h = 0; h < 2; h++) begin
        logic lvl;
        lvl = (h == 0) ? ~de : de;
        step(lvl);
        if (lvl == de) begin
          if (!dbl || !ph) bit_no = (bit_no < 0) ? 0 : (bit_no + 1) % FB;
          if (dbl) ph = ~ph;
        end
        if (lvl == fe) fsx = (bit_no == 0);
        ed = (bit_no < 0) ? 1'b1 : (val ? dat[7 - (bit_no % 8)] : 1'b1);
        eu = (bit_no >= 0) && !val;
        // R3 R4 R5 R6 R7 R8: line state after every bit-clock edge
        chk($sformatf("R3/R4/R5/R6/R7/R8 vec=%h bit=%0d", v, bit_no),
            {sdata, fsync, underrun}, {ed, fsx ^ pol, eu});
      end
    end
  endtask

  initial begin
    repeat (LIMIT) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog act=hung exp=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1 reset outputs", {sdata, fsync, underrun, hold_take}, 4'b1000);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk("R1 after release", {sdata, fsync, underrun, hold_take}, 4'b1000);

    for (int i = 0; i < 6; i++) begin
      run_vec(VECS[i], 20);
      // R7: one take per byte boundary (bits 0, 8, 16) when valid
      chk($sformatf("R7 takes vec %0d", i), takes, VECS[i][8] ? 3 : 0);
    end

    // R2: mid-frame disable idles the line at once and takes nothing
    run_vec(VECS[1], 5);
    @(negedge clk) tx_en = 1'b0;
    @(negedge clk);
    chk("R2 idle after disable", {sdata, fsync, underrun}, {1'b1, fs_pol, 1'b0});
    takes = 0;
    for (int k = 0; k < 6; k++) step(k[0]);
    chk("R2 idle while off", {sdata, fsync, underrun}, {1'b1, fs_pol, 1'b0});
    chk("R2 no take while off", takes, 0);

    // R8: re-enable restarts at frame bit 0 with sync
    run_vec(VECS[0], 3);
    run_vec(VECS[3], 2);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule